// File: doc/BRIEF.md
# Granule Tag Check Engine

This engine decides whether a memory access may proceed by checking its pointer tag against stored tags. The address space is cut into 16-byte granules, and each granule owns a 4-bit stored tag. Two of these tags are packed into each byte of a separate tag memory. When a check starts, the engine works out which granules the access covers. It reads the tag bytes through a synchronous port with one cycle of read latency and compares the granules one at a time, in either ascending or descending order. It stops at the first granule whose stored tag differs from the tag carried in the pointer.

For each run the engine reports four results, all held until the next run finishes:
- a pass/fail verdict;
- how many granules matched;
- a precise fault address;
- how many bytes, counted from the pointer, can be accessed before the failing granule.

The check is skipped, and the access passes, in two cases. The first is when top-byte tagging is turned off for the half of the address space the pointer falls in. The second is when the pointer carries the match-everything tag for that half and that behaviour is enabled.

Top module: `granule_tag_checker`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `pass_o`, `tmem_rd_o` and `match_cnt_o` are all zero.
- R2: Granule g maps to tag byte g>>1, and that byte index appears on `tmem_addr_o`. The even granule of a pair (address bit 4 clear) uses bits [3:0] of the byte, and the odd granule uses bits [7:4]. The first byte read is the one holding the granule of the pointer.
- R3: The pointer tag is `ptr_i[59:56]`, and the byte address is `ptr_i[55:0]`. In forward mode (`reverse_i`=0), the check covers granules floor(a/16) through floor((a+size)/16), where `size` is `size_m1_i`. When every covered granule matches, `pass_o`=1 and `match_cnt_o` equals the number of covered granules.
- R4: The forward walk starts at the high nibble when the first granule is odd, and otherwise at the low nibble. After each high nibble that matches, the next byte is fetched. The walk stops at the first mismatch with `pass_o`=0, and `match_cnt_o` holds the number of matches that came before it.
- R5: In forward mode, `fault_addr_o` is `ptr_i` itself when the first granule fails or the check passes. Otherwise it is `ptr_i[63:56]` joined with the first byte address of the failing granule.
- R6: `ok_bytes_o` is `size_m1_i`+1 on a pass and 0 when the first granule fails. Otherwise, in forward mode, it is n×16 − (a mod 16), where n is the match count.
- R7: In reverse mode (`reverse_i`=1), the check covers granules floor(a/16) down to floor((a−size)/16). Within a byte the high nibble is checked before the low one, and the byte index decreases. After n>0 matches the fault address is the last byte of the failing granule, and `ok_bytes_o` is a minus that address.
- R8: Bit 55 of the pointer selects a bit of `tbi_en_i`. When that bit is 0, the run passes with `match_cnt_o`=0, `fault_addr_o`=`ptr_i` and `ok_bytes_o`=`size_m1_i`+1, and no tag read is issued.
- R9: The same bypass applies when `match_all_en_i[bit55]` is 1 and the pointer tag is 0x0 (bit 55 clear) or 0xF (bit 55 set). With that enable bit at 0, such a tag is checked normally.
- R10: `done_o` is a one-cycle pulse. It is high after clock edge number 1+F+C, where edge 1 is the edge that samples `start_i`, F is the number of bytes fetched and C the number of compares made. A bypassed run gives F=C=0. Results stay unchanged until the next run completes.
- R11: `start_i` is ignored while `busy_o` is high, and the run in progress completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a check with the operands below |
| ptr_i | input | PTR_W | Tagged pointer |
| size_m1_i | input | SIZE_W | Access length in bytes minus one |
| reverse_i | input | 1 | Walk granules downward from the pointer |
| tbi_en_i | input | 2 | Top-byte tagging enable per address half, indexed by bit 55 |
| match_all_en_i | input | 2 | Match-everything tag enable per address half |
| tmem_rd_o | output | 1 | Tag memory read strobe |
| tmem_addr_o | output | MEM_AW | Tag byte index |
| tmem_data_i | input | 8 | Tag byte, valid the cycle after the strobe |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | All covered granules matched, or the check was bypassed |
| match_cnt_o | output | CNT_W | Granules matched before a stop |
| fault_addr_o | output | PTR_W | First failing address |
| ok_bytes_o | output | SIZE_W+1 | Bytes accessible before the failing granule |

## Verification
The completion pulse is due a fixed number of edges after the edge that sampled `start_i`. That number is one plus the bytes fetched plus the compares made, so a bypassed run finishes on the next edge. The bench computes this latency for each run from the expected match count and the granule pairing, counts edges at falling clocks until `done_o` appears, and compares the two counts. It samples all results in that same low phase. It also counts the read strobes at each rising edge, which checks the fetch count and the index of the first byte read, and it checks that the results stay put for several cycles after the pulse.

// File: rtl/tce_pkg.sv
package tce_pkg;

   localparam int TAG_W  = 4;
   localparam int BYTE_W = 2 * TAG_W;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_CMP,
      ST_DONE
   } tce_state_e;

endpackage

// File: rtl/tce_span.sv
module tce_span import tce_pkg::*; #(
   parameter int PTR_W   = 64,
   parameter int TAG_LSB = 56,
   parameter int SEL_BIT = 55,
   parameter int GRAN_LG = 4,
   parameter int SIZE_W  = 12,
   parameter int CNT_W   = 9,
   parameter bit REV_EN  = 1'b1,
   localparam int AW     = TAG_LSB,
   localparam int GW     = AW - GRAN_LG,
   localparam int HI     = TAG_LSB + TAG_W
) (
   input  logic [HI-1:0]     ptr_i,
   input  logic [SIZE_W-1:0] size_m1_i,
   input  logic              reverse_i,
   input  logic [1:0]        tbi_en_i,
   input  logic [1:0]        match_all_en_i,
   output logic              bypass_o,
   output logic              rev_o,
   output logic [GW-1:0]     start_g_o,
   output logic [CNT_W-1:0]  cnt_o
);

   logic [AW-1:0]    addr;
   logic [AW-1:0]    size_x;
   logic [TAG_W-1:0] tag;
   logic             sel;
   logic             match_all;
   logic [GW-1:0]    span_fwd;
   logic [GW-1:0]    span;

   assign addr      = ptr_i[AW-1:0];
   assign size_x    = AW'(size_m1_i);
   assign tag       = ptr_i[HI-1:TAG_LSB];
   assign sel       = ptr_i[SEL_BIT];
   assign start_g_o = addr[AW-1:GRAN_LG];

   // the match-everything tag is all zeros in the low half, all ones in the high half
   assign match_all = match_all_en_i[sel] && (tag == {TAG_W{sel}});
   assign bypass_o  = !tbi_en_i[sel] || match_all;

   assign span_fwd  = GW'((addr + size_x) >> GRAN_LG) - start_g_o;

   generate
      if (REV_EN) begin : g_rev
         logic [GW-1:0] span_rev;
         assign span_rev = start_g_o - GW'((addr - size_x) >> GRAN_LG);
         assign span     = reverse_i ? span_rev : span_fwd;
         assign rev_o    = reverse_i;
      end else begin : g_fwd_only
         assign span  = span_fwd;
         assign rev_o = 1'b0;
      end
   endgenerate

   assign cnt_o = span[CNT_W-1:0] + CNT_W'(1);

endmodule

// File: rtl/tce_nib_cmp.sv
module tce_nib_cmp import tce_pkg::*; (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic              odd_i,
   output logic              match_o
);

   logic [BYTE_W-1:0] diff;

   // copy the tag into both halves so either nibble can be tested in place
   assign diff    = byte_i ^ {tag_i, tag_i};
   assign match_o = odd_i ? (diff[BYTE_W-1:TAG_W] == '0) : (diff[TAG_W-1:0] == '0);

endmodule

// File: rtl/tce_result.sv
module tce_result #(
   parameter int PTR_W   = 64,
   parameter int AW      = 56,
   parameter int GRAN_LG = 4,
   parameter int SIZE_W  = 12,
   localparam int GW     = AW - GRAN_LG,
   localparam int OK_W   = SIZE_W + 1
) (
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [SIZE_W-1:0] size_m1_i,
   input  logic [GW-1:0]     cur_g_i,
   input  logic              rev_i,
   input  logic              none_ok_i,
   input  logic              all_ok_i,
   output logic [PTR_W-1:0]  fault_o,
   output logic [OK_W-1:0]   ok_bytes_o
);

   logic [AW-1:0] addr;
   logic [AW-1:0] g_lo;
   logic [AW-1:0] g_hi;
   logic [AW-1:0] edge_a;
   logic [AW-1:0] reach;

   assign addr   = ptr_i[AW-1:0];
   assign g_lo   = {cur_g_i, {GRAN_LG{1'b0}}};
   assign g_hi   = {cur_g_i, {GRAN_LG{1'b1}}};
   assign edge_a = rev_i ? g_hi : g_lo;
   assign reach  = rev_i ? (addr - g_hi) : (g_lo - addr);

   always_comb begin
      if (all_ok_i) begin
         fault_o    = ptr_i;
         ok_bytes_o = OK_W'(size_m1_i) + OK_W'(1);
      end else if (none_ok_i) begin
         fault_o    = ptr_i;
         ok_bytes_o = '0;
      end else begin
         fault_o    = {ptr_i[PTR_W-1:AW], edge_a};
         ok_bytes_o = reach[OK_W-1:0];
      end
   end

endmodule

// File: rtl/granule_tag_checker.sv
module granule_tag_checker import tce_pkg::*; #(
   parameter int PTR_W   = 64,
   parameter int TAG_LSB = 56,
   parameter int SEL_BIT = 55,
   parameter int GRAN_LG = 4,
   parameter int SIZE_W  = 12,
   parameter int MEM_AW  = 16,
   parameter bit REV_EN  = 1'b1,
   localparam int AW     = TAG_LSB,
   localparam int GW     = AW - GRAN_LG,
   localparam int CNT_W  = SIZE_W - GRAN_LG + 1,
   localparam int OK_W   = SIZE_W + 1,
   localparam int HI     = TAG_LSB + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [SIZE_W-1:0] size_m1_i,
   input  logic              reverse_i,
   input  logic [1:0]        tbi_en_i,
   input  logic [1:0]        match_all_en_i,
   output logic              tmem_rd_o,
   output logic [MEM_AW-1:0] tmem_addr_o,
   input  logic [BYTE_W-1:0] tmem_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              pass_o,
   output logic [CNT_W-1:0]  match_cnt_o,
   output logic [PTR_W-1:0]  fault_addr_o,
   output logic [OK_W-1:0]   ok_bytes_o
);

   generate
      if (HI > PTR_W) begin : g_bad_tag
         $error("tag field does not fit in the pointer");
      end
      if (SEL_BIT >= TAG_LSB) begin : g_bad_sel
         $error("half select bit must lie below the tag field");
      end
      if (SIZE_W <= GRAN_LG) begin : g_bad_size
         $error("size field must be wider than the granule offset");
      end
      if (GW <= MEM_AW || CNT_W > GW) begin : g_bad_mem
         $error("granule index too narrow for the tag memory or count");
      end
   endgenerate

   tce_state_e        state;
   logic [PTR_W-1:0]  ptr_q;
   logic [SIZE_W-1:0] size_q;
   logic              rev_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  n_q;
   logic [GW-1:0]     cur_g;
   logic [BYTE_W-1:0] byte_q;
   logic              fresh_q;

   logic              bypass_w;
   logic              rev_w;
   logic [GW-1:0]     start_g_w;
   logic [CNT_W-1:0]  cnt_w;
   logic [BYTE_W-1:0] cur_byte;
   logic              nib_match;
   logic              last_step;
   logic [PTR_W-1:0]  res_fault;
   logic [OK_W-1:0]   res_ok;

   tce_span #(
      .PTR_W   (PTR_W),
      .TAG_LSB (TAG_LSB),
      .SEL_BIT (SEL_BIT),
      .GRAN_LG (GRAN_LG),
      .SIZE_W  (SIZE_W),
      .CNT_W   (CNT_W),
      .REV_EN  (REV_EN)
   ) u_span (
      .ptr_i          (ptr_i[HI-1:0]),
      .size_m1_i      (size_m1_i),
      .reverse_i      (reverse_i),
      .tbi_en_i       (tbi_en_i),
      .match_all_en_i (match_all_en_i),
      .bypass_o       (bypass_w),
      .rev_o          (rev_w),
      .start_g_o      (start_g_w),
      .cnt_o          (cnt_w)
   );

   // a freshly fetched byte comes straight from the port, a second nibble from the copy
   assign cur_byte = fresh_q ? tmem_data_i : byte_q;

   tce_nib_cmp u_cmp (
      .byte_i  (cur_byte),
      .tag_i   (ptr_q[HI-1:TAG_LSB]),
      .odd_i   (cur_g[0]),
      .match_o (nib_match)
   );

   tce_result #(
      .PTR_W   (PTR_W),
      .AW      (AW),
      .GRAN_LG (GRAN_LG),
      .SIZE_W  (SIZE_W)
   ) u_res (
      .ptr_i      (ptr_q),
      .size_m1_i  (size_q),
      .cur_g_i    (cur_g),
      .rev_i      (rev_q),
      .none_ok_i  (n_q == '0),
      .all_ok_i   (nib_match),
      .fault_o    (res_fault),
      .ok_bytes_o (res_ok)
   );

   assign last_step   = (n_q + CNT_W'(1)) == cnt_q;
   assign tmem_rd_o   = (state == ST_FETCH);
   assign tmem_addr_o = cur_g[MEM_AW:1];
   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         ptr_q        <= '0;
         size_q       <= '0;
         rev_q        <= 1'b0;
         cnt_q        <= '0;
         n_q          <= '0;
         cur_g        <= '0;
         byte_q       <= '0;
         fresh_q      <= 1'b0;
         pass_o       <= 1'b0;
         match_cnt_o  <= '0;
         fault_addr_o <= '0;
         ok_bytes_o   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  ptr_q  <= ptr_i;
                  size_q <= size_m1_i;
                  rev_q  <= rev_w;
                  cnt_q  <= cnt_w;
                  cur_g  <= start_g_w;
                  n_q    <= '0;
                  if (bypass_w) begin
                     pass_o       <= 1'b1;
                     match_cnt_o  <= '0;
                     fault_addr_o <= ptr_i;
                     ok_bytes_o   <= OK_W'(size_m1_i) + OK_W'(1);
                     state        <= ST_DONE;
                  end else begin
                     state <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: begin
               fresh_q <= 1'b1;
               state   <= ST_CMP;
            end
            ST_CMP: begin
               fresh_q <= 1'b0;
               byte_q  <= cur_byte;
               if (!nib_match || last_step) begin
                  pass_o       <= nib_match;
                  match_cnt_o  <= nib_match ? cnt_q : n_q;
                  fault_addr_o <= res_fault;
                  ok_bytes_o   <= res_ok;
                  state        <= ST_DONE;
               end else begin
                  n_q <= n_q + CNT_W'(1);
                  if (rev_q) begin
                     cur_g <= cur_g - GW'(1);
                     state <= cur_g[0] ? ST_CMP : ST_FETCH;
                  end else begin
                     cur_g <= cur_g + GW'(1);
                     state <= cur_g[0] ? ST_FETCH : ST_CMP;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2
   rd_then_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmem_rd_o |=> (!tmem_rd_o && busy_o && !done_o));

   // R6
   fail_ok_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !pass_o) |-> (ok_bytes_o <= OK_W'(size_q)));

   // R5
   first_fail_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !pass_o && (match_cnt_o == '0)) |-> (fault_addr_o == ptr_q));

   // R3
   pass_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && pass_o && (match_cnt_o != '0)) |-> (match_cnt_o == cnt_q));

   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(ptr_q));

endmodule

// File: tb/granule_tag_checker_bench.sv
`timescale 1ns/1ps
module granule_tag_checker_bench;

   localparam int CNT_W = 9;
   localparam int NV    = 10;

   typedef struct packed {
      logic [15:0] addr;
      logic [11:0] sz;
      logic        rev;
      logic [3:0]  tag;
      logic [7:0]  poison;
      logic        pass;
      logic [8:0]  n;
   } vec_t;

   // address, size-1, reverse, tag, poisoned granule (FF none), expected pass, expected matches
   localparam vec_t VEC [NV] = '{
      '{16'h0100, 12'd15,  1'b0, 4'h5, 8'hFF, 1'b1, 9'd1},
      '{16'h0110, 12'd31,  1'b0, 4'h5, 8'hFF, 1'b1, 9'd2},
      '{16'h0105, 12'd63,  1'b0, 4'h5, 8'd18, 1'b0, 9'd2},
      '{16'h0118, 12'd7,   1'b0, 4'h5, 8'd17, 1'b0, 9'd0},
      '{16'h0200, 12'd255, 1'b0, 4'h5, 8'd47, 1'b0, 9'd15},
      '{16'h013F, 12'd47,  1'b1, 4'h5, 8'hFF, 1'b1, 9'd3},
      '{16'h0128, 12'd40,  1'b1, 4'h5, 8'd17, 1'b0, 9'd1},
      '{16'h0131, 12'd0,   1'b1, 4'h5, 8'd19, 1'b0, 9'd0},
      '{16'h07F0, 12'd15,  1'b0, 4'h5, 8'hFF, 1'b1, 9'd1},
      '{16'h0100, 12'd31,  1'b0, 4'h3, 8'hFF, 1'b0, 9'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] ptr_i = '0;
   logic [11:0] size_m1_i = '0;
   logic        reverse_i = 1'b0;
   logic [1:0]  tbi_en_i = 2'b11;
   logic [1:0]  match_all_en_i = 2'b00;
   logic        tmem_rd_o;
   logic [15:0] tmem_addr_o;
   logic [7:0]  tmem_data_i = '0;
   logic        busy_o;
   logic        done_o;
   logic        pass_o;
   logic [CNT_W-1:0] match_cnt_o;
   logic [63:0] fault_addr_o;
   logic [12:0] ok_bytes_o;

   logic [7:0]  tmem [64];
   int          checks = 0;
   int          fails = 0;
   int          rd_cnt = 0;
   logic [15:0] first_rd = '0;
   bit          mon_en = 1'b0;
   int          lat = 0;

   always #2.5 clk = ~clk;

   granule_tag_checker u_granule_tag_checker (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .ptr_i          (ptr_i),
      .size_m1_i      (size_m1_i),
      .reverse_i      (reverse_i),
      .tbi_en_i       (tbi_en_i),
      .match_all_en_i (match_all_en_i),
      .tmem_rd_o      (tmem_rd_o),
      .tmem_addr_o    (tmem_addr_o),
      .tmem_data_i    (tmem_data_i),
      .busy_o         (busy_o),
      .done_o         (done_o),
      .pass_o         (pass_o),
      .match_cnt_o    (match_cnt_o),
      .fault_addr_o   (fault_addr_o),
      .ok_bytes_o     (ok_bytes_o)
   );

   always @(posedge clk) begin
      if (tmem_rd_o) tmem_data_i <= tmem[tmem_addr_o[5:0]];
      if (mon_en && tmem_rd_o) begin
         if (rd_cnt == 0) first_rd = tmem_addr_o;
         rd_cnt = rd_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic fill_mem();
      for (int b = 0; b < 64; b++) tmem[b] = 8'h55;
   endtask

   task automatic poison(input int g);
      if (g[0]) tmem[g >> 1][7:4] = 4'hA;
      else      tmem[g >> 1][3:0] = 4'hA;
   endtask

   task automatic launch(input logic [63:0] p, input logic [11:0] sz, input logic rev);
      @(negedge clk);
      ptr_i = p; size_m1_i = sz; reverse_i = rev; start_i = 1'b1;
      rd_cnt = 0; mon_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat = 1;
      while (!done_o && lat < 2000) begin
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      mon_en = 1'b0;
   endtask

   task automatic expect_run(input logic [63:0] p, input logic [11:0] sz, input logic rev,
                             input logic xpass, input int xn, input bit byp, input string req);
      longint a, g0, c, f, xlat, xok, edge_a;
      logic [63:0] xfault;
      launch(p, sz, rev);
      a  = longint'(p[55:0]);
      g0 = a >>> 4;
      c  = byp ? 0 : (xpass ? xn : xn + 1);
      if (byp)      f = 0;
      else if (!rev) f = ((g0 + c - 1) >>> 1) - (g0 >>> 1) + 1;
      else           f = (g0 >>> 1) - ((g0 - c + 1) >>> 1) + 1;
      xlat = 1 + f + c;
      if (xpass || xn == 0) begin
         xfault = p;
         xok    = xpass ? longint'(sz) + 1 : 0;
      end else if (!rev) begin
         edge_a = (g0 + xn) * 16;
         xfault = {p[63:56], 56'(edge_a)};
         xok    = edge_a - a;
      end else begin
         edge_a = (g0 - xn) * 16 + 15;
         xfault = {p[63:56], 56'(edge_a)};
         xok    = a - edge_a;
      end
      chk({req, " pass"}, 64'(pass_o), 64'(xpass));
      chk({req, " match count"}, 64'(match_cnt_o), 64'(xn));
      chk(rev ? "R7 fault address" : "R5 fault address", fault_addr_o, xfault);
      chk(rev ? "R7 ok bytes" : "R6 ok bytes", 64'(ok_bytes_o), 64'(xok));
      chk("R10 done latency", 64'(lat), 64'(xlat));
      chk("R2 read count", 64'(rd_cnt), 64'(f));
      if (f > 0) chk("R2 first byte index", 64'(first_rd), 64'(g0 >>> 1));
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [63:0] p;
      logic [8:0]  hold_cnt;
      logic [63:0] hold_fault;
      fill_mem();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done", 64'(done_o), 64'd0);
      chk("R1 busy", 64'(busy_o), 64'd0);
      chk("R1 pass", 64'(pass_o), 64'd0);
      chk("R1 read", 64'(tmem_rd_o), 64'd0);
      chk("R1 count", 64'(match_cnt_o), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 R4 R5 R6 R7 vector table
      for (int i = 0; i < NV; i++) begin
         fill_mem();
         if (VEC[i].poison != 8'hFF) poison(int'(VEC[i].poison));
         p = {4'h0, VEC[i].tag, 40'h0, VEC[i].addr};
         expect_run(p, VEC[i].sz, VEC[i].rev, VEC[i].pass, int'(VEC[i].n), 1'b0,
                    VEC[i].pass ? "R3" : "R4");
      end

      // R10 results held after the pulse
      hold_cnt   = match_cnt_o;
      hold_fault = fault_addr_o;
      repeat (5) @(negedge clk);
      chk("R10 done low after pulse", 64'(done_o), 64'd0);
      chk("R10 count held", 64'(match_cnt_o), 64'(hold_cnt));
      chk("R10 fault held", fault_addr_o, hold_fault);

      // R8 tagging disabled for the upper half
      fill_mem();
      tbi_en_i = 2'b01;
      expect_run({4'h0, 4'h5, 1'b1, 39'h0, 16'h0100}, 12'd31, 1'b0, 1'b1, 0, 1'b1, "R8");
      tbi_en_i = 2'b11;

      // R9 match-everything tags
      match_all_en_i = 2'b01;
      expect_run({4'h0, 4'h0, 40'h0, 16'h0100}, 12'd15, 1'b0, 1'b1, 0, 1'b1, "R9 low half");
      match_all_en_i = 2'b10;
      expect_run({4'h0, 4'hF, 1'b1, 39'h0, 16'h0100}, 12'd15, 1'b0, 1'b1, 0, 1'b1, "R9 high half");
      expect_run({4'h0, 4'h0, 40'h0, 16'h0100}, 12'd15, 1'b0, 1'b0, 0, 1'b0, "R9 enable off");
      match_all_en_i = 2'b00;

      // R11 second start while busy
      fill_mem();
      poison(47);
      @(negedge clk);
      ptr_i = {4'h0, 4'h5, 40'h0, 16'h0200}; size_m1_i = 12'd255; reverse_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
      ptr_i = {4'h0, 4'h5, 40'h0, 16'h0100}; size_m1_i = 12'd15; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < 100 && !done_o; k++) @(negedge clk);
      chk("R11 pass", 64'(pass_o), 64'd0);
      chk("R11 count", 64'(match_cnt_o), 64'd15);
      chk("R11 fault address", fault_addr_o, {8'h05, 56'h2F0});
      @(negedge clk);
      chk("R11 idle after run", 64'(busy_o), 64'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule